// File: doc/BRIEF.md
# Channel-Attention Startup Sequencer

This block performs the controller's first handshake with shared memory. After reset it sits idle and issues no memory traffic. When the host strobes the channel-attention input, it reads a two-word configuration record from a fixed address. The first word carries the addressing-mode field and the second points to an intermediate record. From the intermediate record it reads an offset word and, unless the mode is linear, a base word, and it forms the control-block address. It then writes completion status back to memory and raises a level interrupt to the host.

Memory is reached through a single-outstanding master port. An access is presented with `mem_req` and retires in the cycle where `mem_rdy` is also high. A watchdog aborts the sequence into a sticky error state if any access goes unanswered. Channel-attention pulses that arrive while a sequence is in progress are remembered, and they start one further sequence once the current one ends.

States, in order: S_IDLE, then S_RD_MODE (configuration word 0), then S_RD_IPTR (configuration word 1), then S_RD_OFS (intermediate record +4). Next comes S_RD_BASE (intermediate record +8), which is skipped in linear mode. The write-back states follow: S_WR_BUSY (intermediate record +0), S_WR_STAT (control block +0) and S_WR_CMD (control block +4), after which the sequencer returns to S_IDLE.

S_ERR is entered in two cases: from S_RD_MODE when the mode field is reserved, or from any access state when the watchdog expires. S_ERR is left only by reset. S_IDLE moves to S_RD_MODE when an attention pulse is present or pending. Every other state advances on `mem_rdy`.

Top module: `init_seq`

## Requirements
- R1: After reset `mem_req`, `irq`, `init_err` and `busy` are 0, and no memory access starts until `attn` is pulsed.
- R2: A sequence makes its reads in this order, all with `mem_we`=0: CFG_ADDR, CFG_ADDR+4, IP+4, and then IP+8 when the mode is not linear. IP is the word read from CFG_ADDR+4.
- R3: The mode is bits [1:0] of the word at CFG_ADDR, and the other bits are ignored. The encodings are 00 compatibility, 01 segmented and 10 linear, and the mode is shown on `mode`. The value 11 moves the sequencer to the error state without any write.
- R4: In compatibility mode, `cb_addr` = (base[23:0] + offset[15:0]) mod 2^24, with the upper bits zero. The base is the word at IP+8 and the offset is the word at IP+4.
- R5: In segmented mode, `cb_addr` = base + offset[15:0], modulo 2^32.
- R6: In linear mode, `cb_addr` is the whole word at IP+4, and IP+8 is never read.
- R7: Completion makes three writes in this order. IP+0 receives 0, which clears the busy flag. CB+0 receives 32'h0000_A000, which has command-done at bit 15 and command-unit-not-ready at bit 13. CB+4 receives 0, which clears the command word.
- R8: `irq` rises on the clock edge after the final write is accepted, stays high until `irq_ack` is seen, and the sequencer is then idle.
- R9: Any number of `attn` pulses during a running sequence causes exactly one further complete sequence after it ends.
- R10: While an access waits for `mem_rdy`, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R11: If an access goes WD_LIMIT (1024) cycles without `mem_rdy`, `init_err` rises and `mem_req` drops. The error is sticky until reset, and `attn` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attn | input | 1 | Channel-attention strobe from the host |
| irq_ack | input | 1 | Host acknowledge that clears the interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW (32) | Byte address of the access |
| mem_wdata | output | DW (32) | Write data |
| mem_rdata | input | DW (32) | Read data, valid together with mem_rdy |
| mem_rdy | input | 1 | Access completes in this cycle |
| irq | output | 1 | Level interrupt to the host |
| init_err | output | 1 | Sticky abort flag |
| busy | output | 1 | A sequence is in progress |
| mode | output | 2 | Addressing mode last read |
| cb_addr | output | AW (32) | Formed control-block address |

## Verification
The main sequence is run with each of the three modes, with offset and base values chosen so that compatibility mode wraps at 24 bits, segmented mode wraps at 32 bits, and linear mode ignores a nonzero base. These cases show whether the correct adder width, the offset truncation and the skipped base read are in place. Junk in the upper bits of the mode word shows whether only the field bits are decoded. The memory latency is varied from zero to several cycles to show whether the request holds steady across wait states. Directed cases cover the reserved mode, attention pulses that arrive during a run, and an access that never completes, checked both before and after the watchdog limit.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RD_MODE, S_RD_IPTR, S_RD_OFS, S_RD_BASE,
        S_WR_BUSY, S_WR_STAT, S_WR_CMD, S_ERR
    } seq_state_t;

    typedef enum logic [1:0] {
        AM_COMPAT = 2'b00,
        AM_SEG    = 2'b01,
        AM_LINEAR = 2'b10,
        AM_RSVD   = 2'b11
    } amode_t;

    localparam int STAT_DONE_BIT = 15;
    localparam int STAT_CUNR_BIT = 13;
endpackage

// File: rtl/init_host_if.sv
module init_host_if (
    input  logic clk,
    input  logic rst_n,
    input  logic attn_i,
    input  logic take_i,
    input  logic done_i,
    input  logic ack_i,
    output logic attn_any_o,
    output logic irq_o
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            if (take_i)      pend_q <= 1'b0;
            else if (attn_i) pend_q <= 1'b1;
            if (done_i)      irq_o <= 1'b1;
            else if (ack_i)  irq_o <= 1'b0;
        end
    end

    assign attn_any_o = pend_q | attn_i;

    // R8: the interrupt level holds until acknowledged
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> irq_o);
endmodule

// File: rtl/init_wdog.sv
module init_wdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic rdy_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT) + 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!req_i || rdy_i)  cnt_q <= '0;
        else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = req_i && !rdy_i && (cnt_q == LAST);

    // R11: the wait counter never passes the limit
    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/init_cb_form.sv
module init_cb_form
    import init_seq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int OFS_W    = 16,
    parameter int NARROW_W = 24
) (
    input  amode_t          mode_i,
    input  logic [AW-1:0]   base_i,
    input  logic [AW-1:0]   ofs_i,
    output logic [AW-1:0]   cb_o
);
    logic [AW-1:0] seg_sum;
    logic [AW-1:0] narrow;

    assign seg_sum = base_i + {{(AW-OFS_W){1'b0}}, ofs_i[OFS_W-1:0]};

    generate
        if (AW > NARROW_W) begin : g_mask
            assign narrow = {{(AW-NARROW_W){1'b0}}, seg_sum[NARROW_W-1:0]};
        end else begin : g_full
            assign narrow = seg_sum;
        end
    endgenerate

    always_comb begin
        unique case (mode_i)
            AM_LINEAR: cb_o = ofs_i;
            AM_SEG:    cb_o = seg_sum;
            default:   cb_o = narrow;
        endcase
    end
endmodule

// File: rtl/init_seq.sv
module init_seq
    import init_seq_pkg::*;
#(
    parameter int              AW       = 32,
    parameter int              DW       = 32,
    parameter logic [AW-1:0]   CFG_ADDR = 32'hFFFF_FFF0,
    parameter int              WD_LIMIT = 1024
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           attn,
    input  logic           irq_ack,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_rdy,
    output logic           irq,
    output logic           init_err,
    output logic           busy,
    output logic [1:0]     mode,
    output logic [AW-1:0]  cb_addr
);
    localparam logic [DW-1:0] STAT_WORD =
        (DW'(1) << STAT_DONE_BIT) | (DW'(1) << STAT_CUNR_BIT);
    localparam logic [AW-1:0] STEP = AW'(4);

    seq_state_t    state;
    amode_t        mode_q;
    logic [AW-1:0] iptr_q, ofs_q, cb_q, cb_formed;
    logic          attn_any, take, done, wd_expire;

    assign take = (state == S_IDLE) && attn_any;
    assign done = (state == S_WR_CMD) && mem_rdy;

    init_host_if u_host (
        .clk(clk), .rst_n(rst_n), .attn_i(attn), .take_i(take),
        .done_i(done), .ack_i(irq_ack), .attn_any_o(attn_any), .irq_o(irq)
    );

    init_wdog #(.LIMIT(WD_LIMIT)) u_wdog (
        .clk(clk), .rst_n(rst_n), .req_i(mem_req), .rdy_i(mem_rdy),
        .expire_o(wd_expire)
    );

    init_cb_form #(.AW(AW)) u_form (
        .mode_i(mode_q), .base_i(mem_rdata[AW-1:0]), .ofs_i(ofs_q),
        .cb_o(cb_formed)
    );

    // state register and captured datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            mode_q <= AM_COMPAT;
            iptr_q <= '0;
            ofs_q  <= '0;
            cb_q   <= '0;
        end else if (wd_expire) begin
            state <= S_ERR;
        end else begin
            unique case (state)
                S_IDLE:    if (attn_any) state <= S_RD_MODE;
                S_RD_MODE: if (mem_rdy) begin
                    if (mem_rdata[1:0] == AM_RSVD) state <= S_ERR;
                    else begin
                        mode_q <= amode_t'(mem_rdata[1:0]);
                        state  <= S_RD_IPTR;
                    end
                end
                S_RD_IPTR: if (mem_rdy) begin
                    iptr_q <= mem_rdata[AW-1:0];
                    state  <= S_RD_OFS;
                end
                S_RD_OFS: if (mem_rdy) begin
                    ofs_q <= mem_rdata[AW-1:0];
                    if (mode_q == AM_LINEAR) begin
                        cb_q  <= mem_rdata[AW-1:0];
                        state <= S_WR_BUSY;
                    end else begin
                        state <= S_RD_BASE;
                    end
                end
                S_RD_BASE: if (mem_rdy) begin
                    cb_q  <= cb_formed;
                    state <= S_WR_BUSY;
                end
                S_WR_BUSY: if (mem_rdy) state <= S_WR_STAT;
                S_WR_STAT: if (mem_rdy) state <= S_WR_CMD;
                S_WR_CMD:  if (mem_rdy) state <= S_IDLE;
                S_ERR:     state <= S_ERR;
                default:   state <= S_ERR;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_RD_MODE: mem_addr = CFG_ADDR;
            S_RD_IPTR: mem_addr = CFG_ADDR + STEP;
            S_RD_OFS:  mem_addr = iptr_q + STEP;
            S_RD_BASE: mem_addr = iptr_q + (STEP << 1);
            S_WR_BUSY: begin mem_we = 1'b1; mem_addr = iptr_q; end
            S_WR_STAT: begin mem_we = 1'b1; mem_addr = cb_q; mem_wdata = STAT_WORD; end
            S_WR_CMD:  begin mem_we = 1'b1; mem_addr = cb_q + STEP; end
            default:   mem_req = 1'b0;
        endcase
    end

    assign init_err = (state == S_ERR);
    assign busy     = (state != S_IDLE) && (state != S_ERR);
    assign mode     = mode_q;
    assign cb_addr  = cb_q;

    // R10: a waiting access keeps its request steady
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy && !wd_expire) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11: the abort is sticky and silences the port
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> (init_err && !mem_req));

    // R3: a reserved mode field aborts
    p_mode_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_MODE && mem_rdy && mem_rdata[1:0] == 2'b11) |=> init_err);

    // R8: the interrupt only follows the last accepted write
    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req && mem_we && mem_rdy && state == S_WR_CMD));

    // R1: an idle sequencer makes no access
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !mem_req);
endmodule

// File: tb/tb_init_seq.sv
`timescale 1ns/1ps
module tb_init_seq;
    localparam logic [31:0] CFG  = 32'hFFFF_FFF0;
    localparam logic [31:0] IPTR = 32'h0000_0200;

    typedef struct packed {
        logic [1:0]  md;
        logic [31:0] ofs;
        logic [31:0] base;
        logic [3:0]  lat;
        logic [31:0] exp_cb;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b00, 32'h7777_0100, 32'hAB12_3400, 4'd0, 32'h0012_3500},
        '{2'b00, 32'h0000_0200, 32'h00FF_FF00, 4'd2, 32'h0000_0100},
        '{2'b01, 32'hFFFF_8010, 32'h1234_0000, 4'd1, 32'h1234_8010},
        '{2'b01, 32'h0000_0020, 32'hFFFF_FFF0, 4'd3, 32'h0000_0010},
        '{2'b10, 32'hDEAD_BEE0, 32'h5555_5555, 4'd0, 32'hDEAD_BEE0},
        '{2'b10, 32'h0000_1000, 32'h5555_5555, 4'd4, 32'h0000_1000}
    };

    logic clk = 0, rst_n = 0, attn = 0, irq_ack = 0, mem_rdy = 0;
    logic mem_req, mem_we, irq, init_err, busy;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, cb_addr;
    logic [1:0] mode;

    logic [31:0] cfg0, ofs_w, base_w;
    logic [3:0]  lat;
    logic        hang;
    int          wc;
    int          n_log;
    logic [31:0] log_addr [64];
    logic        log_we   [64];
    logic [31:0] log_data [64];
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    init_seq dut (
        .clk(clk), .rst_n(rst_n), .attn(attn), .irq_ack(irq_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .irq(irq), .init_err(init_err), .busy(busy), .mode(mode),
        .cb_addr(cb_addr)
    );

    always_comb begin
        if (mem_addr == CFG)              mem_rdata = cfg0;
        else if (mem_addr == CFG + 4)     mem_rdata = IPTR;
        else if (mem_addr == IPTR + 4)    mem_rdata = ofs_w;
        else if (mem_addr == IPTR + 8)    mem_rdata = base_w;
        else                              mem_rdata = 32'h0BAD_0BAD;
    end

    always @(negedge clk) begin
        if (!mem_req || hang) begin mem_rdy <= 0; wc <= 0; end
        else if (mem_rdy)     begin mem_rdy <= 0; wc <= 0; end
        else if (wc >= int'(lat)) mem_rdy <= 1;
        else wc <= wc + 1;
    end

    always @(posedge clk) begin
        if (mem_req && mem_rdy && n_log < 64) begin
            log_addr[n_log] <= mem_addr;
            log_we[n_log]   <= mem_we;
            log_data[n_log] <= mem_wdata;
            n_log <= n_log + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic pulse_attn();
        @(negedge clk) attn = 1;
        @(negedge clk) attn = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; hang = 0; lat = 0; n_log = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic chk_txn(input int idx, input logic [31:0] a, input logic w,
                           input logic [31:0] d, input string tag);
        chk({tag, " addr"}, log_addr[idx], a);
        chk({tag, " we"}, {31'b0, log_we[idx]}, {31'b0, w});
        if (w) chk({tag, " data"}, log_data[idx], d);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog timeout got 0 exp 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cfg0 = 0; ofs_w = 0; base_w = 0; lat = 0; hang = 0; wc = 0; n_log = 0;
        do_reset();
        // R1: reset state and quiet port
        chk("R1 req", {31'b0, mem_req}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 err", {31'b0, init_err}, 0);
        chk("R1 busy", {31'b0, busy}, 0);
        repeat (20) @(negedge clk);
        chk("R1 no access without attn", n_log, 0);

        for (int i = 0; i < 6; i++) begin
            int   b;
            logic lin;
            lin    = (VECS[i].md == 2'b10);
            cfg0   = 32'hAAAA_AAA8 | {30'b0, VECS[i].md};
            ofs_w  = VECS[i].ofs;
            base_w = VECS[i].base;
            lat    = VECS[i].lat;
            n_log  = 0;
            pulse_attn();
            wait_idle();
            @(negedge clk);
            chk_txn(0, CFG, 0, 0, "R2 rd cfg0");
            chk_txn(1, CFG + 4, 0, 0, "R2 rd cfg1");
            chk_txn(2, IPTR + 4, 0, 0, "R2 rd ofs");
            if (!lin) chk_txn(3, IPTR + 8, 0, 0, "R2 rd base");
            b = lin ? 3 : 4;
            chk("R6 txn count", n_log, b + 3);
            chk_txn(b,     IPTR,                 1, 32'h0, "R7 clear busy");
            chk_txn(b + 1, VECS[i].exp_cb,       1, 32'h0000_A000, "R7 status");
            chk_txn(b + 2, VECS[i].exp_cb + 4,   1, 32'h0, "R7 cmd word");
            chk("R3 mode", {30'b0, mode}, {30'b0, VECS[i].md});
            case (VECS[i].md)
                2'b00:   chk("R4 compat cb", cb_addr, VECS[i].exp_cb);
                2'b01:   chk("R5 seg cb", cb_addr, VECS[i].exp_cb);
                default: chk("R6 linear cb", cb_addr, VECS[i].exp_cb);
            endcase
            chk("R8 irq high", {31'b0, irq}, 1);
            repeat (5) @(negedge clk);
            chk("R8 irq held", {31'b0, irq}, 1);
            irq_ack = 1; @(negedge clk); irq_ack = 0;
            chk("R8 irq cleared", {31'b0, irq}, 0);
            chk("R8 idle", {31'b0, busy}, 0);
            chk("R10 no err", {31'b0, init_err}, 0);
        end

        // R3: reserved mode aborts without writes
        cfg0 = 32'h0000_0003; n_log = 0; lat = 1;
        pulse_attn();
        repeat (10) @(negedge clk);
        chk("R3 reserved err", {31'b0, init_err}, 1);
        chk("R3 reserved one access", n_log, 1);
        chk("R3 no irq", {31'b0, irq}, 0);

        // R9: attention during a run gives exactly one more run
        do_reset();
        cfg0 = 32'h0000_0001; ofs_w = 32'h0000_0040; base_w = 32'h0001_0000; lat = 1;
        pulse_attn();
        repeat (3) @(negedge clk);
        pulse_attn();
        pulse_attn();
        for (int k = 0; k < 400 && (n_log < 14 || busy); k++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R9 two runs", n_log, 14);
        chk("R9 second starts at cfg", log_addr[7], CFG);
        chk("R9 second last write", log_addr[13], 32'h0001_0044);
        chk("R9 idle after", {31'b0, busy}, 0);

        // R11: stalled access
        do_reset();
        hang = 1;
        pulse_attn();
        repeat (1000) @(negedge clk);
        chk("R11 not yet expired", {31'b0, init_err}, 0);
        chk("R10 req held while stalled", {31'b0, mem_req}, 1);
        repeat (100) @(negedge clk);
        chk("R11 expired", {31'b0, init_err}, 1);
        chk("R11 req dropped", {31'b0, mem_req}, 0);
        hang = 0;
        pulse_attn();
        repeat (10) @(negedge clk);
        chk("R11 attn ignored", {31'b0, mem_req}, 0);
        chk("R11 still err", {31'b0, init_err}, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule